// File: doc/BRIEF.md
# Four-Lane Swizzling Vector ALU

This block is the arithmetic stage of a small shader-style datapath. Each operand is a four-lane vector whose lanes are named x, y, z and w. Before the operation, each source passes through its own swizzle selector, so a single instruction can reorder lanes, replicate one lane or do both. The block then runs the same operation in all four lanes at once. A per-lane write mask decides which lanes of the destination take the new value.

The caller supplies the current destination contents together with the instruction. Lanes the mask does not enable come back unchanged, so the returned vector is ready to write straight back to a register file. Integer lanes stand in for floating point. The two comparison operations give numeric 1 and 0 lane values rather than condition flags, so their results can feed later arithmetic as selection factors. One scalar form adds the x lanes of the two swizzled operands and copies the sum to every enabled lane. The result is registered and appears one cycle after the instruction, with a matching valid bit.

Top module: `swz_vec_alu`

## Requirements
- R1: Lane k of a swizzled operand (lane 0 = x in bits 15:0, lane 3 = w in bits 63:48) equals the source lane whose index is the swizzle field bits [2k+1:2k]. One source lane may feed several result lanes.
- R2: Opcode 000 (add) gives the lane-wise sum of the swizzled operands, modulo 2^16.
- R3: Opcode 001 (multiply) gives the low 16 bits of the lane-wise product.
- R4: Opcode 010 (minimum) gives the lane-wise signed minimum of the two swizzled operands.
- R5: Opcode 011 (set-less-than) gives 16'd1 in a lane where the first swizzled operand is signed-less than the second, and 16'd0 otherwise.
- R6: Opcode 100 (set-greater-equal) gives 16'd1 where the first swizzled operand is signed-greater-or-equal to the second, and 16'd0 otherwise.
- R7: Opcode 101 (scalar add) computes the sum of lane x of each swizzled operand and writes that one value to every enabled lane.
- R8: Write mask bit k set means result lane k takes the computed value. Bit k clear means result lane k equals lane k of the destination input.
- R9: Opcodes 110 and 111 are reserved. For these, every result lane equals the destination input, whatever the mask.
- R10: The result and out_valid update on the clock edge that samples in_valid high. After a cycle with in_valid low, out_valid is 0 and the result holds its previous value.
- R11: After reset, out_valid is 0 and the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| op | input | 3 | Operation code |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| swz_a | input | 8 | Swizzle field for src_a, 2 bits per result lane |
| swz_b | input | 8 | Swizzle field for src_b, 2 bits per result lane |
| wr_mask | input | 4 | Per-lane write enable, bit k for lane k |
| dst_old | input | 64 | Current destination contents |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 64 | Merged destination vector |

## Verification
The assertions check several properties on every cycle. They check the valid timing and that the result holds while idle. They check that every lane not written keeps the destination input, which also covers the reserved opcodes. They check that comparison lanes only ever hold 0 or 1, and that a fully enabled scalar add leaves all four lanes equal. The numeric values need the bench's scenarios to show them. Those include the correct lane chosen by each swizzle code, wrap-around in add and multiply, and signed ordering at equal and negative operands. A full sweep over both swizzle fields, run across every opcode and mask, lets the bench's own arithmetic model cover these cases.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LANE_W_DEF = 16;
  localparam int NLANES_DEF = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_MUL  = 3'b001,
    OP_MIN  = 3'b010,
    OP_SLT  = 3'b011,
    OP_SGE  = 3'b100,
    OP_SADD = 3'b101
  } vop_e;
endpackage

// File: rtl/swz_select.sv
module swz_select #(
  parameter int LANE_W = 16,
  parameter int NLANES = 4,
  localparam int SEL_W = $clog2(NLANES),
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic [VEC_W-1:0]        src,
  input  logic [NLANES*SEL_W-1:0] sel,
  output logic [VEC_W-1:0]        dst
);
  logic [LANE_W-1:0] src_lane [NLANES];

  for (genvar s = 0; s < NLANES; s++) begin : g_unpack
    assign src_lane[s] = src[s*LANE_W +: LANE_W];
  end

  // R1: each result lane picks its own source lane
  for (genvar k = 0; k < NLANES; k++) begin : g_route
    assign dst[k*LANE_W +: LANE_W] = src_lane[sel[k*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/swz_lane_alu.sv
module swz_lane_alu import swz_pkg::*; #(
  parameter int LANE_W = 16,
  parameter int NLANES = 4,
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic [2:0]       op,
  output logic [VEC_W-1:0] res
);
  localparam logic [LANE_W-1:0] ONE  = LANE_W'(1);
  localparam logic [LANE_W-1:0] ZERO = '0;

  function automatic logic [LANE_W-1:0] f_add(logic [LANE_W-1:0] a, logic [LANE_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [LANE_W-1:0] f_mul(logic [LANE_W-1:0] a, logic [LANE_W-1:0] b);
    return a * b;
  endfunction

  function automatic logic f_lt(logic [LANE_W-1:0] a, logic [LANE_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic [LANE_W-1:0] f_min(logic [LANE_W-1:0] a, logic [LANE_W-1:0] b);
    return f_lt(a, b) ? a : b;
  endfunction

  logic [LANE_W-1:0] scalar_sum;
  assign scalar_sum = f_add(opa[LANE_W-1:0], opb[LANE_W-1:0]);

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = opa[k*LANE_W +: LANE_W];
    assign lb = opb[k*LANE_W +: LANE_W];
    always_comb begin
      unique case (op)
        OP_ADD:  res[k*LANE_W +: LANE_W] = f_add(la, lb);
        OP_MUL:  res[k*LANE_W +: LANE_W] = f_mul(la, lb);
        OP_MIN:  res[k*LANE_W +: LANE_W] = f_min(la, lb);
        OP_SLT:  res[k*LANE_W +: LANE_W] = f_lt(la, lb) ? ONE : ZERO;
        OP_SGE:  res[k*LANE_W +: LANE_W] = f_lt(la, lb) ? ZERO : ONE;
        OP_SADD: res[k*LANE_W +: LANE_W] = scalar_sum;
        default: res[k*LANE_W +: LANE_W] = ZERO;
      endcase
    end
  end
endmodule

// File: rtl/swz_mask_merge.sv
module swz_mask_merge #(
  parameter int LANE_W = 16,
  parameter int NLANES = 4,
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic [VEC_W-1:0]  computed,
  input  logic [VEC_W-1:0]  old,
  input  logic [NLANES-1:0] wen,
  output logic [VEC_W-1:0]  merged
);
  for (genvar k = 0; k < NLANES; k++) begin : g_merge
    assign merged[k*LANE_W +: LANE_W] =
      wen[k] ? computed[k*LANE_W +: LANE_W] : old[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/swz_vec_alu.sv
module swz_vec_alu import swz_pkg::*; #(
  parameter int LANE_W = LANE_W_DEF,
  parameter int NLANES = NLANES_DEF,
  localparam int SEL_W = $clog2(NLANES),
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              op,
  input  logic [VEC_W-1:0]        src_a,
  input  logic [VEC_W-1:0]        src_b,
  input  logic [NLANES*SEL_W-1:0] swz_a,
  input  logic [NLANES*SEL_W-1:0] swz_b,
  input  logic [NLANES-1:0]       wr_mask,
  input  logic [VEC_W-1:0]        dst_old,
  output logic                    out_valid,
  output logic [VEC_W-1:0]        result
);
  logic [VEC_W-1:0]  opa_swz, opb_swz, lane_res, merged;
  logic              op_known;
  logic [NLANES-1:0] lane_wr_en;

  swz_select #(.LANE_W(LANE_W), .NLANES(NLANES)) i_sel_a (
    .src(src_a), .sel(swz_a), .dst(opa_swz));

  swz_select #(.LANE_W(LANE_W), .NLANES(NLANES)) i_sel_b (
    .src(src_b), .sel(swz_b), .dst(opb_swz));

  swz_lane_alu #(.LANE_W(LANE_W), .NLANES(NLANES)) i_alu (
    .opa(opa_swz), .opb(opb_swz), .op(op), .res(lane_res));

  // R9: reserved codes write no lane
  assign op_known   = op inside {OP_ADD, OP_MUL, OP_MIN, OP_SLT, OP_SGE, OP_SADD};
  assign lane_wr_en = wr_mask & {NLANES{op_known}};

  swz_mask_merge #(.LANE_W(LANE_W), .NLANES(NLANES)) i_merge (
    .computed(lane_res), .old(dst_old), .wen(lane_wr_en), .merged(merged));

  // R10, R11: one register stage, result held while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end
endmodule

// File: rtl/swz_vec_alu_chk.sv
module swz_vec_alu_chk #(
  parameter int LANE_W = 16,
  parameter int NLANES = 4,
  localparam int VEC_W = LANE_W * NLANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [NLANES-1:0] wr_mask,
  input logic [NLANES-1:0] lane_wr_en,
  input logic [VEC_W-1:0]  dst_old,
  input logic              out_valid,
  input logic [VEC_W-1:0]  result
);
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_reserved_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op[2:1] == 2'b11) |=> result == $past(dst_old));

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    p_unwritten_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !lane_wr_en[k] |=>
        result[k*LANE_W +: LANE_W] == $past(dst_old[k*LANE_W +: LANE_W]));

    p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_wr_en[k] && (op == 3'b011 || op == 3'b100) |=>
        result[k*LANE_W +: LANE_W] <= LANE_W'(1));

    p_scalar_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 3'b101 && (&wr_mask) |=>
        result[k*LANE_W +: LANE_W] == result[LANE_W-1:0]);
  end
endmodule

bind swz_vec_alu swz_vec_alu_chk #(.LANE_W(LANE_W), .NLANES(NLANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wr_mask(wr_mask),
  .lane_wr_en(lane_wr_en), .dst_old(dst_old), .out_valid(out_valid),
  .result(result));

// File: tb/test_swz_vec_alu.sv
`timescale 1ns/1ps
module test_swz_vec_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [7:0]  swz_a = '0, swz_b = '0;
  logic [3:0]  wr_mask = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  swz_vec_alu i_swz_vec_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .swz_a(swz_a), .swz_b(swz_b),
    .wr_mask(wr_mask), .dst_old(dst_old), .out_valid(out_valid),
    .result(result));

  function automatic logic [15:0] pick(logic [63:0] v, logic [1:0] s);
    logic [63:0] t;
    t = v >> (s * 16);
    return t[15:0];
  endfunction

  function automatic logic [63:0] model(logic [2:0] o, logic [63:0] a, logic [63:0] b,
                                         logic [7:0] sa, logic [7:0] sb,
                                         logic [3:0] m, logic [63:0] old);
    logic [63:0] out;
    int x, y, r;
    out = old;
    for (int k = 0; k < 4; k++) begin
      x = $signed(pick(a, sa[2*k +: 2]));
      y = $signed(pick(b, sb[2*k +: 2]));
      case (o)
        3'd0: r = x + y;
        3'd1: r = x * y;
        3'd2: r = (x < y) ? x : y;
        3'd3: r = (x < y) ? 1 : 0;
        3'd4: r = (x >= y) ? 1 : 0;
        3'd5: r = $signed(pick(a, sa[1:0])) + $signed(pick(b, sb[1:0]));
        default: r = 0;
      endcase
      if (m[k] && o < 3'd6) out[16*k +: 16] = 16'(r);
    end
    return out;
  endfunction

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(string tag, logic [2:0] o, logic [63:0] a, logic [63:0] b,
                       logic [7:0] sa, logic [7:0] sb, logic [3:0] m, logic [63:0] old);
    logic [63:0] exp;
    exp = model(o, a, b, sa, sb, m, old);
    op = o; src_a = a; src_b = b; swz_a = sa; swz_b = sb; wr_mask = m; dst_old = old;
    in_valid = 1'b1;
    @(negedge clk);
    check(tag, result, exp);
    check("R10", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic idle_check();
    logic [63:0] held;
    held = result;
    in_valid = 1'b0;
    op = 3'd0; src_a = ~src_a; dst_old = ~dst_old; wr_mask = 4'hF;
    @(negedge clk);
    check("R10", result, held);
    check("R10", {63'd0, out_valid}, 64'd0);
  endtask

  function automatic logic [63:0] rv();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", result, 64'd0);
    check("R11", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);

    // R1: identity, reversal, replication with add against zero
    do_op("R1", 3'd0, 64'h0004_0003_0002_0001, 64'd0, 8'b11_10_01_00, 8'd0, 4'hF, 64'd0);
    check("R1", result, 64'h0004_0003_0002_0001);
    do_op("R1", 3'd0, 64'h0004_0003_0002_0001, 64'd0, 8'b00_01_10_11, 8'd0, 4'hF, 64'd0);
    check("R1", result, 64'h0001_0002_0003_0004);
    do_op("R1", 3'd0, 64'h0004_0003_0002_0001, 64'd0, 8'b01_01_01_01, 8'd0, 4'hF, 64'd0);
    check("R1", result, 64'h0002_0002_0002_0002);
    idle_check();

    // corner values
    do_op("R2", 3'd0, {4{16'h7FFF}}, {4{16'h0001}}, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R2", result, {4{16'h8000}});
    do_op("R3", 3'd1, {4{16'h0100}}, {4{16'h0100}}, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R3", result, 64'd0);
    do_op("R3", 3'd1, {4{16'hFFFF}}, {4{16'h0003}}, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R3", result, {4{16'hFFFD}});
    do_op("R4", 3'd2, {4{16'hFFFF}}, {4{16'h0001}}, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R4", result, {4{16'hFFFF}});
    do_op("R5", 3'd3, 64'h0005_FFFB_8000_0007, 64'h0005_0003_7FFF_0002, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R5", result, 64'h0000_0001_0001_0000);
    do_op("R6", 3'd4, 64'h0005_FFFB_8000_0007, 64'h0005_0003_7FFF_0002, 8'hE4, 8'hE4, 4'hF, 64'd0);
    check("R6", result, 64'h0001_0000_0000_0001);
    do_op("R7", 3'd5, 64'h0000_0000_0000_000A, 64'h0000_0000_0014_0000, 8'h00, 8'h01, 4'b1011, 64'hAAAA_BBBB_CCCC_DDDD);
    check("R7", result, 64'h001E_BBBB_001E_001E);
    do_op("R8", 3'd0, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111, 8'hE4, 8'hE4, 4'b0101, 64'hAAAA_BBBB_CCCC_DDDD);
    check("R8", result, 64'hAAAA_2222_CCCC_2222);
    do_op("R9", 3'd6, rv(), rv(), 8'hE4, 8'h1B, 4'hF, 64'h1234_5678_9ABC_DEF0);
    check("R9", result, 64'h1234_5678_9ABC_DEF0);
    do_op("R9", 3'd7, rv(), rv(), 8'h55, 8'hAA, 4'hF, 64'h0F0F_F0F0_1357_2468);
    check("R9", result, 64'h0F0F_F0F0_1357_2468);
    idle_check();

    // every opcode against every mask with random data (R2..R9)
    for (int o = 0; o < 8; o++) begin
      for (int m = 0; m < 16; m++) begin
        for (int n = 0; n < 8; n++) begin
          do_op(op_tag(3'(o)), 3'(o), rv(), rv(), 8'($urandom), 8'($urandom), 4'(m), rv());
        end
      end
    end
    idle_check();

    // R1: full sweep over both swizzle fields, opcode and mask varied
    for (int sa = 0; sa < 256; sa++) begin
      for (int sb = 0; sb < 256; sb++) begin
        do_op("R1", 3'((sa + sb) % 6), rv(), rv(), 8'(sa), 8'(sb),
              4'(sa) ^ 4'(sb >> 4), rv());
      end
    end
    idle_check();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule